// File: doc/BRIEF.md
# I2C Slave Receiver with Event Status Codes

This block is the receive side of an I2C target. It watches the SCL and SDA lines, finds START and STOP conditions, and compares each address byte with a 7-bit own address and with the general call address. After it accepts an address it takes in data bytes and acknowledges or refuses each one. Each bus event that matters to software is reported as an 8-bit status code with an interrupt flag. While that flag is set the block holds SCL low, so the bus waits until software has taken the byte.

Software answers each event with a control write. The write carries an acknowledge-enable bit and clears the flag. The block keeps that bit. It decides whether the next data byte is ACKed. After the block leaves the addressed state, the same bit decides whether it still answers its own address or the general call. A strobe input reports that a master in the same device has just lost arbitration. If an address match follows, it is reported with a separate code.

Top module: `i2c_srx_top`

## Requirements
- R1: With the kept acknowledge-enable bit at 1, an address byte equal to {own_addr, 0} is ACKed in the ninth clock. Then status becomes 0x60 and irq rises.
- R2: After an arb_lost strobe, the next accepted own address reports 0x68 and the next accepted general call reports 0x78. The strobe is used up by that report, so the match after it reports 0x60 again.
- R3: The address byte 0x00 is ACKed and reports 0x70 only when gc_en is 1. With gc_en at 0 it gets no ACK and causes no status change.
- R4: A data byte received under the own address is ACKed with status 0x80 if the acknowledge-enable bit written at the previous handshake was 1. It is NACKed with status 0x88 if that bit was 0. In both cases rx_data holds the byte, received MSB first.
- R5: A data byte received under the general call reports 0x90 when ACKed and 0x98 when NACKed, on the same acknowledge rule as R4.
- R6: A STOP or a repeated START while the block is addressed reports 0xA0. After a repeated START the address byte that follows is decoded normally.
- R7: A handshake that answers 0x88, 0x98 or 0xA0 with ack_en at 0 stops all address recognition. The same handshake with ack_en at 1 lets the own address be recognised again.
- R8: status[2:0] is always 0. status reads 0xF8 whenever irq is low, which covers reset and the cycle after each handshake. While irq is high, irq and status stay unchanged until ctl_wr.
- R9: While irq is high and SCL is low, scl_oe holds SCL low. The handshake releases it.
- R10: An address byte with bit 0 set to 1, or one that matches neither address, is not ACKed and changes no status. The bytes that follow it are ignored until the next START.
- R11: After a data byte has been NACKed, the block ignores further bytes and a STOP until the next START.
- R12: A ctl_wr while irq is low changes only the kept acknowledge-enable bit. irq stays low and status stays 0xF8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr | input | 7 | Own 7-bit address |
| gc_en | input | 1 | Accept the general call address |
| ack_en | input | 1 | Acknowledge-enable value taken at ctl_wr |
| ctl_wr | input | 1 | Control write strobe: keeps ack_en, clears irq |
| arb_lost | input | 1 | Strobe: the local master lost arbitration |
| irq | output | 1 | Event pending, handshake required |
| status | output | 8 | Event status code |
| rx_data | output | 8 | Last received data byte |

## Verification
The checks assume that the bus master changes SDA only while SCL is low, except at START and STOP. They also assume that the master waits for SCL to be released before it treats a clock as high. The bench master works on each level for twenty system clocks. It waits on the wired SCL line before it counts a high phase, and it changes data only in the low phase. The checks further assume that software answers a 0xA0 raised by a STOP before a new START appears. SCL is not held in that case, so the bench always writes the handshake before it issues the next START.

// File: rtl/i2c_srx_pkg.sv
// Shared constants and types for the I2C slave receiver.
package i2c_srx_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADR_W    = 7;
    localparam int CODE_W   = 5;
    localparam int PAD_W    = BYTE_W - CODE_W;

    // Status values: upper five bits of the reported code.
    typedef enum logic [CODE_W-1:0] {
        SC_OWN_W     = 5'h0C,
        SC_OWN_W_AL  = 5'h0D,
        SC_GC        = 5'h0E,
        SC_GC_AL     = 5'h0F,
        SC_OWN_DACK  = 5'h10,
        SC_OWN_DNACK = 5'h11,
        SC_GC_DACK   = 5'h12,
        SC_GC_DNACK  = 5'h13,
        SC_END       = 5'h14,
        SC_IDLE      = 5'h1F
    } stat_e;

    typedef enum logic [2:0] {
        LK_IDLE, LK_ADDR, LK_AACK, LK_DATA, LK_DACK
    } link_e;

    typedef enum logic [1:0] {
        AM_NONE, AM_OWN, AM_GC
    } amode_e;
endpackage

// File: rtl/i2c_srx_sync.sv
// Synchroniser and edge detector for a set of slow input lines.
// Assumes the inputs idle high; the reset value is 1 so that no edge is seen at start-up.
module i2c_srx_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        // Move the raw level through the synchroniser chain and keep the previous level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], raw[g]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign lvl[g]  = chain_q[STAGES-1];
        assign rise[g] = chain_q[STAGES-1] & ~prev_q;
        assign fall[g] = ~chain_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/i2c_srx_link.sv
// Bit-level receive engine: START/STOP detection, address match, byte shifting,
// ACK drive and event generation. It freezes while hold is high, so the state it
// has at an event is the state it resumes in after the handshake.
// Assumes the master changes SDA only while SCL is low, except at START/STOP.
module i2c_srx_link
    import i2c_srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [ADR_W-1:0]  own_addr,
    input  logic              gc_en,
    input  logic              ack_q,
    input  logic              arb_q,
    output logic              sda_oe,
    output logic              ev_valid,
    output stat_e             ev_code,
    output logic [BYTE_W-1:0] ev_data,
    output logic              stop_seen
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    link_e              st_q;
    amode_e             mode_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [BYTE_W-1:0]  sh_q;
    logic               gc_hit_q;
    logic               acked_q;

    logic start_c, stop_c, own_match, gc_match, addr_ok;
    stat_e addr_code, data_code;

    // Bus conditions and address decode.
    assign start_c   = scl_lvl & sda_fall;
    assign stop_c    = scl_lvl & sda_rise;
    assign own_match = (sh_q[BYTE_W-1:1] == own_addr) && !sh_q[0];
    assign gc_match  = gc_en && (sh_q == '0);
    assign addr_ok   = ack_q && (gc_match || own_match);
    assign ev_data   = sh_q;

    // Choose the code for an accepted address and for a completed data byte.
    always_comb begin
        if (gc_hit_q) addr_code = arb_q ? SC_GC_AL : SC_GC;
        else          addr_code = arb_q ? SC_OWN_W_AL : SC_OWN_W;
        if (mode_q == AM_GC) data_code = acked_q ? SC_GC_DACK : SC_GC_DNACK;
        else                 data_code = acked_q ? SC_OWN_DACK : SC_OWN_DNACK;
    end

    // Main receive state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= LK_IDLE;
            mode_q    <= AM_NONE;
            cnt_q     <= '0;
            sh_q      <= '0;
            gc_hit_q  <= 1'b0;
            acked_q   <= 1'b0;
            sda_oe    <= 1'b0;
            ev_valid  <= 1'b0;
            ev_code   <= SC_IDLE;
            stop_seen <= 1'b0;
        end else begin
            ev_valid  <= 1'b0;
            stop_seen <= 1'b0;
            if (!hold) begin
                if (start_c) begin
                    st_q   <= LK_ADDR;
                    cnt_q  <= '0;
                    sda_oe <= 1'b0;
                    if (mode_q != AM_NONE) begin
                        ev_valid <= 1'b1;
                        ev_code  <= SC_END;
                        mode_q   <= AM_NONE;
                    end
                end else if (stop_c) begin
                    st_q      <= LK_IDLE;
                    sda_oe    <= 1'b0;
                    stop_seen <= 1'b1;
                    if (mode_q != AM_NONE) begin
                        ev_valid <= 1'b1;
                        ev_code  <= SC_END;
                        mode_q   <= AM_NONE;
                    end
                end else begin
                    case (st_q)
                        LK_ADDR, LK_DATA: begin
                            if (scl_rise) begin
                                sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
                                cnt_q <= cnt_q + 1'b1;
                            end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
                                cnt_q <= '0;
                                if (st_q == LK_ADDR) begin
                                    if (addr_ok) begin
                                        sda_oe   <= 1'b1;
                                        gc_hit_q <= gc_match;
                                        st_q     <= LK_AACK;
                                    end else begin
                                        st_q <= LK_IDLE;
                                    end
                                end else begin
                                    sda_oe  <= ack_q;
                                    acked_q <= ack_q;
                                    st_q    <= LK_DACK;
                                end
                            end
                        end
                        LK_AACK: begin
                            if (scl_fall) begin
                                sda_oe   <= 1'b0;
                                mode_q   <= gc_hit_q ? AM_GC : AM_OWN;
                                ev_valid <= 1'b1;
                                ev_code  <= addr_code;
                                st_q     <= LK_DATA;
                            end
                        end
                        LK_DACK: begin
                            if (scl_fall) begin
                                sda_oe   <= 1'b0;
                                ev_valid <= 1'b1;
                                ev_code  <= data_code;
                                if (acked_q) begin
                                    st_q <= LK_DATA;
                                end else begin
                                    st_q   <= LK_IDLE;
                                    mode_q <= AM_NONE;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/i2c_srx_hshake.sv
// Software-facing side: interrupt flag, status code, received byte, the kept
// acknowledge-enable bit, the arbitration-lost marker and the SCL stretch.
// Assumes the engine raises at most one event per handshake.
module i2c_srx_hshake
    import i2c_srx_pkg::*;
#(
    parameter logic ACK_RST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  stat_e             ev_code,
    input  logic [BYTE_W-1:0] ev_data,
    input  logic              stop_seen,
    input  logic              ctl_wr,
    input  logic              ack_en,
    input  logic              arb_lost,
    input  logic              scl_lvl,
    output logic              irq,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] rx_data,
    output logic              ack_q,
    output logic              arb_q,
    output logic              scl_oe
);
    stat_e code_q;
    logic  is_data_ev, is_addr_ev;

    assign is_data_ev = ev_valid && (ev_code inside {SC_OWN_DACK, SC_OWN_DNACK, SC_GC_DACK, SC_GC_DNACK});
    assign is_addr_ev = ev_valid && (ev_code inside {SC_OWN_W, SC_OWN_W_AL, SC_GC, SC_GC_AL});

    // Interrupt flag and status code: set by an event, returned to idle by the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq    <= 1'b0;
            code_q <= SC_IDLE;
        end else if (ev_valid) begin
            irq    <= 1'b1;
            code_q <= ev_code;
        end else if (ctl_wr && irq) begin
            irq    <= 1'b0;
            code_q <= SC_IDLE;
        end
    end

    // Keep the acknowledge-enable bit on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ack_q <= ACK_RST;
        else if (ctl_wr) ack_q <= ack_en;
    end

    // Keep the byte from each data event.
    always_ff @(posedge clk) begin
        if (!rst_n)          rx_data <= '0;
        else if (is_data_ev) rx_data <= ev_data;
    end

    // Arbitration-lost marker: used by the next address report or cleared by STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)                       arb_q <= 1'b0;
        else if (arb_lost)                arb_q <= 1'b1;
        else if (is_addr_ev || stop_seen) arb_q <= 1'b0;
    end

    assign status = {code_q, {PAD_W{1'b0}}};
    assign scl_oe = irq & ~scl_lvl;
endmodule

// File: rtl/i2c_srx_top.sv
// I2C slave receiver top: synchroniser, receive engine and software handshake.
// Assumes the bus lines are slow compared with clk (several clocks per level).
module i2c_srx_top
    import i2c_srx_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic ACK_RST     = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADR_W-1:0]  own_addr,
    input  logic              gc_en,
    input  logic              ack_en,
    input  logic              ctl_wr,
    input  logic              arb_lost,
    output logic              irq,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] rx_data
);
    localparam int L_SCL = 0;
    localparam int L_SDA = 1;

    logic [1:0]        s_lvl, s_rise, s_fall;
    logic              ev_valid, stop_seen, ack_q, arb_q, hold;
    stat_e             ev_code;
    logic [BYTE_W-1:0] ev_data;

    assign hold = irq | ev_valid;

    i2c_srx_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({sda_i, scl_i}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    i2c_srx_link u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .scl_lvl  (s_lvl[L_SCL]),
        .scl_rise (s_rise[L_SCL]),
        .scl_fall (s_fall[L_SCL]),
        .sda_lvl  (s_lvl[L_SDA]),
        .sda_rise (s_rise[L_SDA]),
        .sda_fall (s_fall[L_SDA]),
        .own_addr (own_addr),
        .gc_en    (gc_en),
        .ack_q    (ack_q),
        .arb_q    (arb_q),
        .sda_oe   (sda_oe),
        .ev_valid (ev_valid),
        .ev_code  (ev_code),
        .ev_data  (ev_data),
        .stop_seen(stop_seen)
    );

    i2c_srx_hshake #(.ACK_RST(ACK_RST)) u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (ev_valid),
        .ev_code  (ev_code),
        .ev_data  (ev_data),
        .stop_seen(stop_seen),
        .ctl_wr   (ctl_wr),
        .ack_en   (ack_en),
        .arb_lost (arb_lost),
        .scl_lvl  (s_lvl[L_SCL]),
        .irq      (irq),
        .status   (status),
        .rx_data  (rx_data),
        .ack_q    (ack_q),
        .arb_q    (arb_q),
        .scl_oe   (scl_oe)
    );
endmodule

// File: rtl/i2c_srx_chk.sv
// Property checker for the I2C slave receiver, bound to the top module.
module i2c_srx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       ctl_wr,
    input logic [7:0] status,
    input logic       scl_oe,
    input logic       sda_oe
);
    AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) status[2:0] == 3'b000); // R8
    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n) !irq |-> status == 8'hF8); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) irq && !ctl_wr |=> irq); // R8
    AST_STAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n) irq && !ctl_wr |=> $stable(status)); // R8
    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) irq && ctl_wr |=> !irq && status == 8'hF8); // R8
    AST_IRQ_CODE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (status inside {8'h60, 8'h68, 8'h70, 8'h78, 8'h80, 8'h88, 8'h90, 8'h98, 8'hA0})); // R8
    AST_SCL_ONLY_IRQ: assert property (@(posedge clk) disable iff (!rst_n) scl_oe |-> irq); // R9
    AST_SDA_FREE_IRQ: assert property (@(posedge clk) disable iff (!rst_n) irq |-> !sda_oe); // R1
endmodule

bind i2c_srx_top i2c_srx_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .irq   (irq),
    .ctl_wr(ctl_wr),
    .status(status),
    .scl_oe(scl_oe),
    .sda_oe(sda_oe)
);

// File: tb/i2c_srx_top_tb_top.sv
`timescale 1ns/1ps
module i2c_srx_top_tb_top;
    localparam int HALF  = 20;
    localparam int NVEC  = 9;
    localparam logic [6:0] OWN = 7'h2A;

    typedef struct packed {
        logic       arb;
        logic       gc;
        logic [7:0] adr;
        logic [7:0] dat;
        logic       dack;
        logic       aack;
        logic [7:0] ast;
        logic [7:0] dst;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 8'h54, 8'hC3, 1'b1, 1'b1, 8'h60, 8'h80},
        '{1'b0, 1'b1, 8'h00, 8'h5A, 1'b1, 1'b1, 8'h70, 8'h90},
        '{1'b0, 1'b1, 8'h54, 8'h11, 1'b0, 1'b1, 8'h60, 8'h88},
        '{1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b1, 8'h70, 8'h98},
        '{1'b1, 1'b1, 8'h54, 8'h01, 1'b1, 1'b1, 8'h68, 8'h80},
        '{1'b1, 1'b1, 8'h00, 8'h80, 1'b1, 1'b1, 8'h78, 8'h90},
        '{1'b0, 1'b1, 8'h55, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00},
        '{1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00},
        '{1'b0, 1'b1, 8'h56, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic gc_en = 1'b1, ack_en = 1'b0, ctl_wr = 1'b0, arb_lost = 1'b0;
    logic scl_oe, sda_oe, irq;
    logic [7:0] status, rx_data;
    logic scl_line, sda_line;
    logic ack;
    vec_t v;
    int n_tests = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    i2c_srx_top dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .gc_en(gc_en),
        .ack_en(ack_en), .ctl_wr(ctl_wr), .arb_lost(arb_lost),
        .irq(irq), .status(status), .rx_data(rx_data)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic scl_high();
        scl_m = 1'b1;
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; tick(HALF);
        scl_high();   tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b0; tick(HALF);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; tick(HALF);
        scl_high();   tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic m_byte(input logic [7:0] b, output logic acked);
        for (int k = 7; k >= 0; k--) begin
            sda_m = b[k]; tick(HALF);
            scl_high();   tick(HALF);
            scl_m = 1'b0; tick(HALF);
        end
        sda_m = 1'b1; tick(HALF);
        scl_high();   tick(HALF);
        acked = ~sda_line;
        scl_m = 1'b0; tick(HALF);
    endtask

    task automatic sw_write(input logic a);
        ack_en = a; ctl_wr = 1'b1; tick(1);
        ctl_wr = 1'b0; tick(3);
    endtask

    task automatic pulse_arb();
        arb_lost = 1'b1; tick(1);
        arb_lost = 1'b0; tick(1);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        finish_run();
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R8 reset state
        chk("R8", "reset status", status, 8'hF8);
        chk("R8", "reset irq", irq, 0);
        chk("R9", "reset scl_oe", scl_oe, 0);
        chk("R1", "reset sda_oe", sda_oe, 0);
        chk("R4", "reset rx_data", rx_data, 0);
        // R12: a control write with irq low keeps status idle
        sw_write(1'b1);
        chk("R12", "irq after idle write", irq, 0);
        chk("R12", "status after idle write", status, 8'hF8);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            gc_en = v.gc;
            if (v.arb) pulse_arb();
            m_start();
            m_byte(v.adr, ack);
            chk(v.adr == 8'h00 ? "R3" : (v.aack ? "R1" : "R10"), "address ack", ack, v.aack);
            if (v.aack) begin
                chk(v.arb ? "R2" : (v.gc && v.adr == 8'h00 ? "R3" : "R1"), "address status", status, v.ast);
                chk("R1", "irq after address", irq, 1);
                sw_write(v.dack);
                m_byte(v.dat, ack);
                chk(v.adr == 8'h00 ? "R5" : "R4", "data ack", ack, v.dack);
                chk(v.adr == 8'h00 ? "R5" : "R4", "data status", status, v.dst);
                chk("R4", "rx_data", rx_data, v.dat);
                sw_write(1'b1);
                m_stop();
                chk(v.dack ? "R6" : "R11", "status after stop", status, v.dack ? 8'hA0 : 8'hF8);
                if (irq) sw_write(1'b1);
            end else begin
                chk("R10", "irq after refused address", irq, 0);
                chk("R10", "status after refused address", status, 8'hF8);
                m_stop();
            end
        end
        gc_en = 1'b1;

        // R9 and R6: stretch, repeated START, arbitration marker used up (R2)
        m_start();
        m_byte(8'h54, ack);
        chk("R2", "status after used-up arb", status, 8'h60);
        chk("R9", "scl_oe during event", scl_oe, 1);
        tick(100);
        chk("R9", "SCL still held", scl_line, 0);
        sw_write(1'b1);
        chk("R9", "scl_oe after handshake", scl_oe, 0);
        m_start();
        chk("R6", "status on repeated START", status, 8'hA0);
        chk("R9", "hold after repeated START", scl_oe, 1);
        sw_write(1'b1);
        m_byte(8'h54, ack);
        chk("R6", "address after repeated START", status, 8'h60);
        sw_write(1'b1);
        m_stop();
        chk("R6", "status on STOP", status, 8'hA0);
        sw_write(1'b1);

        // R11: after a NACKed byte, bytes and STOP are ignored
        m_start();
        m_byte(8'h54, ack);
        sw_write(1'b0);
        m_byte(8'h33, ack);
        chk("R4", "NACK status", status, 8'h88);
        sw_write(1'b1);
        m_byte(8'h54, ack);
        chk("R11", "byte after NACK ack", ack, 0);
        chk("R11", "byte after NACK status", status, 8'hF8);
        m_stop();
        chk("R11", "STOP after NACK irq", irq, 0);

        // R10: bytes after a mismatched address are ignored
        m_start();
        m_byte(8'h56, ack);
        m_byte(8'h54, ack);
        chk("R10", "byte after mismatch ack", ack, 0);
        chk("R10", "byte after mismatch irq", irq, 0);
        m_stop();

        // R7: recognition follows the bit written at the 0x88 / 0xA0 handshake
        m_start();
        m_byte(8'h54, ack);
        sw_write(1'b0);
        m_byte(8'h77, ack);
        sw_write(1'b0);
        m_stop();
        m_start();
        m_byte(8'h54, ack);
        chk("R7", "own address after disable", ack, 0);
        chk("R7", "status after disable", status, 8'hF8);
        m_stop();
        m_start();
        m_byte(8'h00, ack);
        chk("R7", "general call after disable", ack, 0);
        m_stop();
        sw_write(1'b1);
        chk("R12", "idle write irq", irq, 0);
        chk("R12", "idle write status", status, 8'hF8);
        m_start();
        m_byte(8'h54, ack);
        chk("R7", "own address after enable", ack, 1);
        sw_write(1'b1);
        m_stop();
        chk("R6", "STOP while addressed", status, 8'hA0);
        sw_write(1'b0);
        m_start();
        m_byte(8'h54, ack);
        chk("R7", "own address after 0xA0 with bit 0", ack, 0);
        m_stop();
        sw_write(1'b1);

        tick(10);
        finish_run();
    end
endmodule